// File: doc/BRIEF.md
# Vector Absolute-Value Max/Min Accumulator

This block updates a 128-bit destination vector lane by lane. Each lane of the source vector is read as a signed two's complement number and its magnitude is formed. That magnitude is then compared, as an unsigned number, with the matching destination lane, which is itself unsigned. Depending on a select input, the larger or the smaller of the two values becomes the new lane value. The same datapath serves both the max form and the min form.

The lane width is chosen per operation: 8, 16 or 32 bits. A 16-bit predicate holds one bit per byte and controls write-back one byte at a time. Bytes that are not enabled keep their old destination value. The merged vector is registered on a valid strobe and presented one cycle later, together with an output valid. The surrounding vector pipeline uses the block as one execute stage.

Top module: `vec_absmm`

## Requirements
- R1: While rst_ni is low and until the first accepted operation, valid_o is 0 and result_o is all zeros.
- R2: When valid_i is high at a rising edge, valid_o is high for exactly the following cycle and result_o carries that operation's result. When valid_i is low, valid_o drops and result_o holds its previous value.
- R3: size_i selects the lane layout. 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, and 2 or 3 give four 32-bit lanes. Lanes are little-endian, so lane e occupies bits [e*W +: W].
- R4: Each source lane is treated as signed, and its absolute value is used in the comparison.
- R5: The most negative source lane value (0x80, 0x8000 or 0x80000000) gives the unsigned magnitude 2^(W-1). It is not saturated and raises no flag.
- R6: The comparison is unsigned against the destination lane. min_sel_i = 0 keeps the larger value and min_sel_i = 1 keeps the smaller.
- R7: mask_i bit b controls result byte b, bits [8b+7:8b]. If the bit is 1, the byte takes the lane result. If it is 0, the byte keeps dst_i. An all-zero mask therefore returns dst_i unchanged.
- R8: When the source magnitude equals the destination lane, the lane result is that common value in both max and min forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Lane width select (0: 8, 1: 16, 2/3: 32 bits) |
| min_sel_i | input | 1 | 0: keep larger, 1: keep smaller |
| mask_i | input | 16 | Byte write-enable predicate |
| dst_i | input | 128 | Destination vector, unsigned lanes |
| src_i | input | 128 | Source vector, signed lanes |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 128 | Registered merged result |

## Verification
The bench feeds the most negative value at each lane width. A design that saturates the magnitude, or compares it as signed, returns 0x7F or keeps the destination instead of 0x80. Equal operands and magnitudes that straddle the destination check the direction of the compare. A swapped max/min select or an off-by-one compare shows up there. All-ones, all-zeros and random partial masks at every lane width catch a mask indexed per lane instead of per byte, and lanes placed big-endian.

// File: rtl/vec_absmm_pkg.sv
package vec_absmm_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LANE_KINDS = 3;  // 8, 16, 32 bit lanes

  typedef enum logic [1:0] {
    SZ_8    = 2'd0,
    SZ_16   = 2'd1,
    SZ_32   = 2'd2,
    SZ_32_A = 2'd3
  } lane_size_e;

  function automatic int unsigned kind_of(input logic [1:0] sz);
    case (lane_size_e'(sz))
      SZ_8:    return 0;
      SZ_16:   return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/vamm_lane.sv
module vamm_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         min_sel_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] mag;
  logic         take_src;

  // magnitude of most negative value wraps to 2^(W-1), read unsigned
  assign mag      = src_i[W-1] ? (~src_i + W'(1)) : src_i;
  assign take_src = min_sel_i ? (mag < dst_i) : (mag > dst_i);
  assign res_o    = take_src ? mag : dst_i;
endmodule

// File: rtl/vamm_slice.sv
module vamm_slice #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic             min_sel_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned NUM_LANES = VEC_W / LANE_W;

  for (genvar e = 0; e < NUM_LANES; e++) begin : g_lane
    vamm_lane #(.W(LANE_W)) u_lane (
      .dst_i    (dst_i[e*LANE_W +: LANE_W]),
      .src_i    (src_i[e*LANE_W +: LANE_W]),
      .min_sel_i(min_sel_i),
      .res_o    (res_o[e*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/vec_absmm.sv
module vec_absmm
  import vec_absmm_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NUM_BYTES = VEC_W / BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           size_i,
  input  logic                 min_sel_i,
  input  logic [NUM_BYTES-1:0] mask_i,
  input  logic [VEC_W-1:0]     dst_i,
  input  logic [VEC_W-1:0]     src_i,
  output logic                 valid_o,
  output logic [VEC_W-1:0]     result_o
);
  logic [VEC_W-1:0] cand [LANE_KINDS];
  logic [VEC_W-1:0] sel_res;
  logic [VEC_W-1:0] merged;

  for (genvar k = 0; k < LANE_KINDS; k++) begin : g_kind
    vamm_slice #(.VEC_W(VEC_W), .LANE_W(BYTE_W << k)) u_slice (
      .dst_i    (dst_i),
      .src_i    (src_i),
      .min_sel_i(min_sel_i),
      .res_o    (cand[k])
    );
  end

  always_comb begin
    sel_res = cand[LANE_KINDS-1];
    for (int k = 0; k < LANE_KINDS; k++)
      if (kind_of(size_i) == k) sel_res = cand[k];
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = mask_i[b] ? sel_res[b*BYTE_W +: BYTE_W]
                                                  : dst_i[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= merged;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
  a_r7_zero_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == '0) |=> result_o == $past(dst_i));
  a_r6_max_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !min_sel_i && size_i == 2'd2 && &mask_i[3:0])
      |=> result_o[31:0] >= $past(dst_i[31:0]));
  a_r6_min_le: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && min_sel_i && size_i == 2'd2 && &mask_i[3:0])
      |=> result_o[31:0] <= $past(dst_i[31:0]));
endmodule

// File: tb/vec_absmm_bench.sv
module vec_absmm_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   size_i = '0;
  logic         min_sel_i = 1'b0;
  logic [15:0]  mask_i = '0;
  logic [127:0] dst_i = '0;
  logic [127:0] src_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [127:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];
  logic [127:0] last_exp = '0;

  always #5 clk = ~clk;

  vec_absmm u_vec_absmm (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .size_i(size_i),
    .min_sel_i(min_sel_i), .mask_i(mask_i), .dst_i(dst_i), .src_i(src_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] s,
                                         input logic [1:0] sz, input logic mn,
                                         input logic [15:0] m);
    logic [127:0] out;
    int nb;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    out = d;
    for (int e = 0; e < 16 / nb; e++) begin
      longint unsigned dv, sv, mag, r;
      dv = 0; sv = 0;
      for (int k = 0; k < nb; k++) begin
        dv |= longint'(d[8*(e*nb+k) +: 8]) << (8*k);
        sv |= longint'(s[8*(e*nb+k) +: 8]) << (8*k);
      end
      if (sv >= (64'd1 << (8*nb-1))) mag = (64'd1 << (8*nb)) - sv;
      else mag = sv;
      if (mn) r = (mag < dv) ? mag : dv;
      else    r = (mag > dv) ? mag : dv;
      for (int k = 0; k < nb; k++)
        if (m[e*nb+k]) out[8*(e*nb+k) +: 8] = 8'(r >> (8*k));
    end
    return out;
  endfunction

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] d, input logic [127:0] s, input logic [1:0] sz,
                       input logic mn, input logic [15:0] m, input string tag);
    item_t it;
    @(posedge clk); #1;
    valid_i = 1'b1; dst_i = d; src_i = s; size_i = sz; min_sel_i = mn; mask_i = m;
    it.exp = model(d, s, sz, mn, m);
    it.tag = tag;
    sb.push_back(it);
    last_exp = it.exp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid_i = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      item_t it;
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected valid_o act=1 exp=0");
      end else begin
        it = sb.pop_front();
        check(result_o, it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] rd, rs;
    #23;
    check({127'd0, valid_o}, 128'd0, "R1 valid in reset");
    check(result_o, 128'd0, "R1 result in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check({127'd0, valid_o}, 128'd0, "R1 valid after reset");

    // R5 most negative at each width, R3 layouts
    drive({16{8'h7f}}, {16{8'h80}}, 2'd0, 1'b0, 16'hffff, "R5 8b max");
    drive({16{8'h7f}}, {16{8'h80}}, 2'd0, 1'b1, 16'hffff, "R5 8b min");
    drive({8{16'h7fff}}, {8{16'h8000}}, 2'd1, 1'b0, 16'hffff, "R5 16b max");
    drive({4{32'h7fffffff}}, {4{32'h80000000}}, 2'd2, 1'b0, 16'hffff, "R5 32b max");
    drive({4{32'h7fffffff}}, {4{32'h80000000}}, 2'd3, 1'b1, 16'hffff, "R3 size3 min");
    // R4 abs of negatives
    drive({16{8'h03}}, {16{8'hfb}}, 2'd0, 1'b0, 16'hffff, "R4 abs -5 max");
    drive({8{16'h0010}}, {8{16'hfff0}}, 2'd1, 1'b1, 16'hffff, "R4 abs min");
    // R6 unsigned dst compare
    drive({4{32'hf0000000}}, {4{32'h7fffffff}}, 2'd2, 1'b0, 16'hffff, "R6 unsigned dst max");
    drive({4{32'hf0000000}}, {4{32'h7fffffff}}, 2'd2, 1'b1, 16'hffff, "R6 unsigned dst min");
    // R8 equal operands
    drive({16{8'h42}}, {16{8'hbe}}, 2'd0, 1'b0, 16'hffff, "R8 equal max");
    drive({4{32'h12345678}}, {4{32'h12345678}}, 2'd2, 1'b1, 16'hffff, "R8 equal min");
    // R7 masks
    drive({16{8'h11}}, {16{8'h7f}}, 2'd0, 1'b0, 16'h0000, "R7 zero mask");
    drive({8{16'h1111}}, {8{16'h8000}}, 2'd1, 1'b0, 16'h5a5a, "R7 partial 16b");
    drive({4{32'h01020304}}, {4{32'h80000000}}, 2'd2, 1'b0, 16'h8421, "R7 partial 32b");
    // R3 little-endian lane placement: distinct lanes
    drive(128'h0, 128'h000000ff_00000001_fffffffe_00000003, 2'd2, 1'b0, 16'hffff, "R3 lane order");
    idle(3);
    @(negedge clk);
    check({127'd0, valid_o}, 128'd0, "R2 valid drops");
    check(result_o, last_exp, "R2 result holds");

    for (int i = 0; i < 80; i++) begin
      rd = {$urandom, $urandom, $urandom, $urandom};
      rs = {$urandom, $urandom, $urandom, $urandom};
      if (i % 7 == 0) rs[31:0] = 32'h80000000;
      drive(rd, rs, 2'($urandom_range(0, 3)), 1'($urandom), 16'($urandom),
            "R6 R7 random");
      if (i % 5 == 0) idle(1);
    end
    idle(4);
    @(negedge clk);
    check(128'(sb.size()), 128'd0, "R2 all results seen");
    check(result_o, last_exp, "R2 final hold");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule